// File: doc/BRIEF.md
# Multiplexed Analog Output Strobe Controller

This block sequences one shared digital-to-analog converter across five sample-and-hold channels. A processor write carries a 12-bit conversion value, a 4-bit channel code and a settling count. The block places the value on the converter input, which feeds every channel at once. It waits the requested number of settling cycles and then raises a strobe for a fixed number of cycles. While the strobe is high, a one-of-eight decoder is enabled, and it pulls low the single active-low latch enable that belongs to the selected channel. That channel captures the converted level.

A busy flag covers the whole sequence, from the accepted write until the strobe clears. Writes that arrive while it is high are dropped. Channel codes 5 to 15 name no channel. They run the same timing but pulse no latch enable, and they raise an error flag. The analog parts are outside the block and appear only as the digital value and the enables.

Top module: `aout_strobe_ctrl`

## Requirements
- R1: After synchronous reset, `latch_n` is 5'b11111 and `busy`, `strobe`, `dac_load`, `sel_err` and `dac_value` are all zero.
- R2: A write (`wr_en` high in a cycle where `busy` is low) is accepted at that clock edge. `dac_value` shows `wr_value` from the next cycle on, and `dac_load` is high for exactly that one cycle.
- R3: `busy` is high from the cycle after the accepting edge for S+L+1 cycles, then low. S is the `settle_cycles` value sampled at acceptance and L is `STROBE_LEN` (default 3).
- R4: `strobe` is low for the first S+1 cycles after acceptance, then high for exactly L cycles, and it falls at the same edge as `busy`.
- R5: While `strobe` is high and the accepted code k is 0 to 4, `latch_n[k]` is 0 and every other bit is 1. At most one bit of `latch_n` is ever low.
- R6: An accepted code of 5 to 15 sets `sel_err` to 1 from the cycle after acceptance and keeps `latch_n` all ones through the sequence. An accepted code of 0 to 4 sets `sel_err` to 0.
- R7: A write while `busy` is high is ignored. `dac_value`, `dac_load`, the timing and the channel pulsed stay as the accepted write set them.
- R8: `latch_n` is all ones in every cycle in which `strobe` is low.
- R9: `dac_value` does not change while `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request from the processor |
| wr_value | input | 12 | Conversion value |
| wr_sel | input | 4 | Channel code, 0 to 4 valid |
| settle_cycles | input | 8 | Settling wait in cycles, sampled at acceptance |
| dac_value | output | 12 | Value presented to the shared converter |
| dac_load | output | 1 | One-cycle pulse when `dac_value` is updated |
| strobe | output | 1 | Output strobe that enables the decoder |
| latch_n | output | 5 | Active-low latch enables, one per channel |
| busy | output | 1 | Sequence in progress |
| sel_err | output | 1 | Last accepted code named no channel |

## Verification
Directed sequences cover each valid code 0 to 4, the invalid codes 5, 7, 8 and 15, and a settling count of zero and of 255. Comparing codes 4 and 5 separates the last real channel from the first decoder line that has no pin. Codes 7 and 8 separate the upper code bit from the low three bits. A settling count of zero, set against larger counts, exposes off-by-one errors in where the strobe starts. Seeded random sequences then mix values, codes, settling counts and intruding writes during busy; a dropped intruding write is recognised because the value, the timing and the channel pulsed all follow the accepted write.

// File: rtl/aout_pkg.sv
package aout_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_STROBE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/aout_port_reg.sv
// Output-port register: holds the converter value and channel code of the
// accepted write, flags codes that name no channel, and pulses a load strobe.
module aout_port_reg #(
  parameter int VAL_W  = 12,
  parameter int SEL_W  = 4,
  parameter int NUM_CH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [VAL_W-1:0] value_in,
  input  logic [SEL_W-1:0] sel_in,
  output logic [VAL_W-1:0] value_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             sel_err_q,
  output logic             load_q
);

  localparam logic [SEL_W-1:0] SEL_LIMIT = SEL_W'(NUM_CH);

  logic code_bad;

  assign code_bad = (sel_in >= SEL_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q   <= '0;
      sel_q     <= '0;
      sel_err_q <= 1'b0;
      load_q    <= 1'b0;
    end else begin
      load_q <= load;
      if (load) begin
        value_q   <= value_in;
        sel_q     <= sel_in;
        sel_err_q <= code_bad;
      end
    end
  end

endmodule

// File: rtl/aout_seq_fsm.sv
// Sequencer: settle wait, then a fixed-length strobe. The strobe and busy
// outputs are registered from the next-state value.
module aout_seq_fsm
  import aout_pkg::*;
#(
  parameter int SETTLE_W   = 8,
  parameter int STROBE_LEN = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_in,
  output logic                accept,
  output logic                strobe_next,
  output logic                strobe_q,
  output logic                busy_q
);

  localparam int LEN_W = $clog2(STROBE_LEN + 1);
  localparam int CNT_W = (SETTLE_W > LEN_W) ? SETTLE_W : LEN_W;
  localparam logic [CNT_W-1:0] STB_LAST = CNT_W'(STROBE_LEN - 1);

  seq_state_e       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    accept  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          accept  = 1'b1;
          state_n = ST_SETTLE;
          cnt_n   = CNT_W'(settle_in);
        end
      end
      ST_SETTLE: begin
        if (cnt == '0) begin
          state_n = ST_STROBE;
          cnt_n   = STB_LAST;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_STROBE: begin
        if (cnt == '0) begin
          state_n = ST_IDLE;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      default: begin
        state_n = ST_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  assign strobe_next = (state_n == ST_STROBE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      strobe_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      state    <= state_n;
      cnt      <= cnt_n;
      strobe_q <= strobe_next;
      busy_q   <= (state_n != ST_IDLE);
    end
  end

endmodule

// File: rtl/aout_sel_decoder.sv
// One-of-eight style decoder with registered active-low outputs. Only the
// lines wired to real channels are built; codes past them match nothing.
module aout_sel_decoder #(
  parameter int SEL_W  = 4,
  parameter int NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [SEL_W-1:0]  code,
  output logic [NUM_CH-1:0] line_n_q
);

  localparam int DEC_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              dec_en;
  logic [NUM_CH-1:0] line_low;

  generate
    if (SEL_W > DEC_W) begin : g_hi
      assign dec_en = en && (code[SEL_W-1:DEC_W] == '0);
    end else begin : g_nohi
      assign dec_en = en;
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_line
      assign line_low[i] = dec_en && (code[DEC_W-1:0] == DEC_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      line_n_q <= '1;
    end else begin
      line_n_q <= ~line_low;
    end
  end

endmodule

// File: rtl/aout_strobe_ctrl.sv
module aout_strobe_ctrl #(
  parameter int VAL_W      = 12,
  parameter int SEL_W      = 4,
  parameter int NUM_CH     = 5,
  parameter int SETTLE_W   = 8,
  parameter int STROBE_LEN = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [VAL_W-1:0]    wr_value,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic [VAL_W-1:0]    dac_value,
  output logic                dac_load,
  output logic                strobe,
  output logic [NUM_CH-1:0]   latch_n,
  output logic                busy,
  output logic                sel_err
);

  logic             accept;
  logic             strobe_next;
  logic [SEL_W-1:0] sel_q;

  aout_seq_fsm #(
    .SETTLE_W  (SETTLE_W),
    .STROBE_LEN(STROBE_LEN)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (wr_en),
    .settle_in  (settle_cycles),
    .accept     (accept),
    .strobe_next(strobe_next),
    .strobe_q   (strobe),
    .busy_q     (busy)
  );

  aout_port_reg #(
    .VAL_W (VAL_W),
    .SEL_W (SEL_W),
    .NUM_CH(NUM_CH)
  ) u_port (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .value_in (wr_value),
    .sel_in   (wr_sel),
    .value_q  (dac_value),
    .sel_q    (sel_q),
    .sel_err_q(sel_err),
    .load_q   (dac_load)
  );

  aout_sel_decoder #(
    .SEL_W (SEL_W),
    .NUM_CH(NUM_CH)
  ) u_dec (
    .clk     (clk),
    .rst     (rst),
    .en      (strobe_next),
    .code    (sel_q),
    .line_n_q(latch_n)
  );

endmodule

// File: rtl/aout_strobe_ctrl_chk.sv
module aout_strobe_ctrl_chk #(
  parameter int VAL_W  = 12,
  parameter int NUM_CH = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [VAL_W-1:0]  dac_value,
  input logic              dac_load,
  input logic              strobe,
  input logic [NUM_CH-1:0] latch_n,
  input logic              busy,
  input logic              sel_err
);

  a_r5_one_enable: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~latch_n));

  a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> (&latch_n));

  a_r3_strobe_in_busy: assert property (@(posedge clk) disable iff (rst)
    strobe |-> busy);

  a_r4_strobe_ends_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe) |-> $fell(busy));

  a_r9_value_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(dac_value)));

  a_r2_load_single: assert property (@(posedge clk) disable iff (rst)
    dac_load |=> !dac_load);

  a_r6_err_no_latch: assert property (@(posedge clk) disable iff (rst)
    sel_err |-> (&latch_n));

  a_r7_busy_drop: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en) |=> !dac_load);

endmodule

bind aout_strobe_ctrl aout_strobe_ctrl_chk #(
  .VAL_W (VAL_W),
  .NUM_CH(NUM_CH)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .dac_value(dac_value),
  .dac_load (dac_load),
  .strobe   (strobe),
  .latch_n  (latch_n),
  .busy     (busy),
  .sel_err  (sel_err)
);

// File: tb/aout_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module aout_strobe_ctrl_bench;

  localparam int VW = 12;
  localparam int SW = 4;
  localparam int NC = 5;
  localparam int TW = 8;
  localparam int L  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [VW-1:0] wr_value = '0;
  logic [SW-1:0] wr_sel = '0;
  logic [TW-1:0] settle_cycles = '0;
  logic [VW-1:0] dac_value;
  logic          dac_load;
  logic          strobe;
  logic [NC-1:0] latch_n;
  logic          busy;
  logic          sel_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  aout_strobe_ctrl #(
    .VAL_W(VW), .SEL_W(SW), .NUM_CH(NC), .SETTLE_W(TW), .STROBE_LEN(L)
  ) u_aout_strobe_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_value(wr_value),
    .wr_sel(wr_sel), .settle_cycles(settle_cycles), .dac_value(dac_value),
    .dac_load(dac_load), .strobe(strobe), .latch_n(latch_n), .busy(busy),
    .sel_err(sel_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_strobe(int k, int s);
    return (k >= s + 1) && (k <= s + L);
  endfunction

  function automatic bit exp_busy(int k, int s);
    return k <= s + L;
  endfunction

  function automatic logic [NC-1:0] exp_latch(int k, int s, int sel);
    logic [NC-1:0] v;
    v = '1;
    if (exp_strobe(k, s) && sel < NC) v[sel] = 1'b0;
    return v;
  endfunction

  // One accepted write followed by the full sequence; optional intruding write.
  task automatic run_seq(input int val, input int sel, input int s, input bit intrude);
    @(negedge clk);
    wr_en = 1'b1; wr_value = VW'(val); wr_sel = SW'(sel); settle_cycles = TW'(s);
    @(negedge clk);
    wr_en = 1'b0;
    check(dac_value == VW'(val), "R2 value", int'(dac_value), val);
    check(dac_load == 1'b1, "R2 load pulse", int'(dac_load), 1);
    check(sel_err == (sel >= NC), "R6 error flag", int'(sel_err), int'(sel >= NC));
    if (intrude) begin
      wr_en = 1'b1; wr_value = ~VW'(val); wr_sel = SW'((sel + 1) % NC);
      settle_cycles = TW'(s + 4);
    end
    for (int k = 0; k <= s + L + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 1) begin
        wr_en = 1'b0;
        if (intrude) begin
          check(dac_value == VW'(val), "R7 value kept", int'(dac_value), val);
          check(dac_load == 1'b0, "R7 no reload", int'(dac_load), 0);
        end
      end
      if (busy != exp_busy(k, s))
        check(1'b0, "R3 busy", int'(busy), int'(exp_busy(k, s)));
      if (strobe != exp_strobe(k, s))
        check(1'b0, "R4 strobe", int'(strobe), int'(exp_strobe(k, s)));
      if (latch_n != exp_latch(k, s, sel))
        check(1'b0, exp_strobe(k, s) ? "R5 latch" : "R8 latch idle",
              int'(latch_n), int'(exp_latch(k, s, sel)));
      if (exp_busy(k, s) && dac_value != VW'(val))
        check(1'b0, "R9 value held", int'(dac_value), val);
    end
    check(1'b1, "R3 R4 R5 sequence", 0, 0);
    check(busy == 1'b0, "R3 busy clear", int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check(latch_n == '1, "R1 latch reset", int'(latch_n), 31);
    rst = 1'b0;
    @(negedge clk);
    check({busy, strobe, dac_load, sel_err} == 4'b0, "R1 flags reset",
          int'({busy, strobe, dac_load, sel_err}), 0);
    check(dac_value == '0, "R1 value reset", int'(dac_value), 0);
    check(latch_n == '1, "R1 latch after reset", int'(latch_n), 31);

    // Directed corners
    for (int c = 0; c < NC; c++) run_seq(12'h100 + c, c, 2, 1'b0);
    run_seq(12'hFFF, 4, 0, 1'b0);
    run_seq(12'h555, 5, 1, 1'b0);
    run_seq(12'h0AA, 7, 0, 1'b0);
    run_seq(12'h123, 8, 2, 1'b0);
    run_seq(12'h321, 15, 3, 1'b0);
    run_seq(12'h7E7, 0, 1, 1'b0);  // valid code clears error (R6)
    run_seq(12'h800, 3, 255, 1'b0);
    run_seq(12'h00F, 2, 1, 1'b1);

    // Seeded random sequences
    for (int n = 0; n < 40; n++) begin
      int v, sl, st;
      v  = int'($urandom % 4096);
      sl = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % NC);
      st = int'($urandom % 7);
      run_seq(v, sl, st, bit'($urandom % 2));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule